// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

This block is the sequencing core of a four-channel DMA controller. It watches per-channel request lines, qualifies each with that channel's mask bit, and picks a winner by fixed priority. While any channel is eligible it asks the host for the bus with a hold request. Once the host answers with hold acknowledge, the engine serves the winning channel with one transfer per clock. On each transfer it presents a physical memory address, a direction and a strobe, steps the channel's address and count, and hands the updated values to the surrounding register block through a writeback port.

The register block owns the programmed state: the mode, the current and base address and count, and the page byte of each channel. The engine copies the winner's current address and count when it is granted and works on that copy, so the register block's writeback latency never stalls a burst. Terminal count is reached when the count wraps from zero to all ones, so a loaded count of N gives N+1 transfers. At that point the channel is either masked or reloaded from its base registers, the terminal-count output pulses, and the bus is released.

Top module: `dma_xfer_engine`

## Requirements
- R1: Channel 0 has the highest priority and the highest index the lowest. A channel is eligible only while its request bit is 1 and its mask bit is 0. Only the granted channel's bit of the one-hot acknowledge vector is ever 1.
- R2: Hold request rises one clock after any channel becomes eligible. It falls once no channel is eligible. A request from a masked channel raises no hold request and causes no transfer.
- R3: The memory address is the channel's page byte in bits 23:16, OR-ed with the current address. In word mode (WORD_MODE=1) the current address is first shifted left by one bit, so that its bit 15 lands on bit 16.
- R4: The first transfer comes two clocks after hold acknowledge is seen. After that one transfer is made per clock while hold acknowledge, the channel's request and its clear mask bit remain. Each transfer adds 1 to the address, or subtracts 1 when mode bit 3 (decrement) is set, and subtracts 1 from the count.
- R5: The transfer made with a count of 0 is the last one, so a loaded count N gives N+1 transfers. On that transfer the terminal-count output is 1 together with the acknowledge, and the channel's terminal-count status bit (status bit n for channel n) is set.
- R6: At terminal count without autoinit (mode bit 2 clear), the writeback carries the stepped address, a count of all ones and a mask-set flag. With autoinit, it carries the base address and base count and no mask-set flag.
- R7: The clock after terminal count, hold request, acknowledge and terminal count are all 0.
- R8: Mode bits 1:0 give the transfer type. Type 1 raises the strobe with the write (device to memory) flag. Type 2 raises the strobe with the read (memory to device) flag. Type 0 (verify) raises no strobe and no flag, yet still steps the address and count and writes them back.
- R9: If the granted channel's request falls mid-burst, its acknowledge falls at the next clock with no terminal count. The engine then moves on to any other eligible channel. Status bit NUM_CH+n follows channel n's request with one clock of delay.
- R10: Terminal-count status bits stay set until a one-clock pulse on tc_clr_i clears all of them.
- R11: A channel whose mode bits 5:4 are 3 (cascade) gets its acknowledge passed through while it requests. It gets no strobe, no writeback and no terminal count, whatever its count.
- R12: After reset, hold request, acknowledge, strobe, terminal count, writeback valid and status are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_CH | Per-channel request lines |
| mask_i | input | NUM_CH | Per-channel mask bits from the register block |
| mode_i | input | NUM_CH*6 | Per-channel mode: [5:4] service, [3] decrement, [2] autoinit, [1:0] type |
| cur_addr_i | input | NUM_CH*ADDR_W | Per-channel current address |
| base_addr_i | input | NUM_CH*ADDR_W | Per-channel base address |
| cur_cnt_i | input | NUM_CH*CNT_W | Per-channel current count |
| base_cnt_i | input | NUM_CH*CNT_W | Per-channel base count |
| page_i | input | NUM_CH*PAGE_W | Per-channel page byte |
| tc_clr_i | input | 1 | Clears all terminal-count status bits |
| hold_ack_i | input | 1 | Bus grant from the host |
| hold_req_o | output | 1 | Bus request to the host |
| ack_o | output | NUM_CH | One-hot channel acknowledge |
| mem_addr_o | output | PAGE_W+ADDR_W | Physical memory address |
| mem_stb_o | output | 1 | Memory access strobe |
| mem_wr_o | output | 1 | Device-to-memory direction |
| mem_rd_o | output | 1 | Memory-to-device direction |
| tc_o | output | 1 | Terminal-count pulse |
| wb_valid_o | output | 1 | Writeback valid |
| wb_ch_o | output | CH_W | Writeback channel index |
| wb_addr_o | output | ADDR_W | Writeback current address |
| wb_cnt_o | output | CNT_W | Writeback current count |
| wb_mask_set_o | output | 1 | Writeback: set the channel's mask bit |
| status_o | output | 2*NUM_CH | [NUM_CH-1:0] terminal-count bits, upper half request-pending bits |

## Verification
Bursts are run with counts of 0, 1, 2 and 3, covering increment and decrement stepping and each transfer type. Counting the acknowledged cycles up to the terminal-count pulse tells a wrap-at-zero design apart from one that stops at zero. A second engine built in word mode receives the same stimulus, and its address is compared with the byte engine's. A page and address pair that overlaps at bit 16 shows whether the shift and the OR are both present. Competing requests, a masked high-priority request, a request removed mid-burst and a cascade channel loaded with a zero count check that arbitration, release and pass-through each leave the count untouched where they should.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  localparam int MODE_W = 6;

  typedef enum logic [1:0] {
    SVC_DEMAND  = 2'd0,
    SVC_SINGLE  = 2'd1,
    SVC_BLOCK   = 2'd2,
    SVC_CASCADE = 2'd3
  } svc_e;

  typedef enum logic [1:0] {
    XT_VERIFY   = 2'd0,
    XT_TO_MEM   = 2'd1,
    XT_FROM_MEM = 2'd2,
    XT_RSVD     = 2'd3
  } xfer_e;

  typedef struct packed {
    svc_e  svc;
    logic  dec;
    logic  reload;
    xfer_e kind;
  } chan_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_BURST = 2'd2,
    ST_REST  = 2'd3
  } eng_state_e;

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic              any_o,
  output logic [CH_W-1:0]   win_o
);

  logic [NUM_CH-1:0] elig;

  assign elig  = req_i & ~mask_i;
  assign any_o = |elig;

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    win_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) win_o = CH_W'(i);
    end
  end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_W    = 8,
  parameter int WORD_MODE = 0
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [PAGE_W-1:0]        page_i,
  input  logic                     dec_i,
  output logic [ADDR_W-1:0]        addr_next_o,
  output logic [CNT_W-1:0]         cnt_next_o,
  output logic                     last_o,
  output logic [PAGE_W+ADDR_W-1:0] phys_o
);

  localparam int PHYS_W = PAGE_W + ADDR_W;

  logic [PHYS_W-1:0] page_part;
  logic [PHYS_W-1:0] offs_part;

  assign page_part = {page_i, {ADDR_W{1'b0}}};

  generate
    if (WORD_MODE != 0) begin : g_word
      assign offs_part = {{(PAGE_W-1){1'b0}}, addr_i, 1'b0};
    end else begin : g_byte
      assign offs_part = {{PAGE_W{1'b0}}, addr_i};
    end
  endgenerate

  assign phys_o      = page_part | offs_part;
  assign addr_next_o = dec_i ? (addr_i - 1'b1) : (addr_i + 1'b1);
  assign cnt_next_o  = cnt_i - 1'b1;
  assign last_o      = (cnt_i == '0);

endmodule

// File: rtl/dma_status_track.sv
module dma_status_track #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   req_i,
  input  logic                tc_set_i,
  input  logic [CH_W-1:0]     tc_ch_i,
  input  logic                tc_clr_i,
  output logic [2*NUM_CH-1:0] status_o
);

  logic [NUM_CH-1:0] tc_q;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] tc_hit;

  assign tc_hit = tc_set_i ? (NUM_CH'(1) << tc_ch_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q   <= '0;
      pend_q <= '0;
    end else begin
      tc_q   <= (tc_clr_i ? '0 : tc_q) | tc_hit;
      pend_q <= req_i;
    end
  end

  assign status_o = {pend_q, tc_q};

  // R10: without a clear, no terminal-count bit ever falls
  a_r10_tc_sticky: assert property (@(posedge clk) disable iff (rst)
    !tc_clr_i |=> ((tc_q & $past(tc_q)) == $past(tc_q)));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_W    = 8,
  parameter int WORD_MODE = 0,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PHYS_W = PAGE_W + ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          req_i,
  input  logic [NUM_CH-1:0]          mask_i,
  input  logic [NUM_CH*MODE_W-1:0]   mode_i,
  input  logic [NUM_CH*ADDR_W-1:0]   cur_addr_i,
  input  logic [NUM_CH*ADDR_W-1:0]   base_addr_i,
  input  logic [NUM_CH*CNT_W-1:0]    cur_cnt_i,
  input  logic [NUM_CH*CNT_W-1:0]    base_cnt_i,
  input  logic [NUM_CH*PAGE_W-1:0]   page_i,
  input  logic                       tc_clr_i,
  input  logic                       hold_ack_i,
  output logic                       hold_req_o,
  output logic [NUM_CH-1:0]          ack_o,
  output logic [PHYS_W-1:0]          mem_addr_o,
  output logic                       mem_stb_o,
  output logic                       mem_wr_o,
  output logic                       mem_rd_o,
  output logic                       tc_o,
  output logic                       wb_valid_o,
  output logic [CH_W-1:0]            wb_ch_o,
  output logic [ADDR_W-1:0]          wb_addr_o,
  output logic [CNT_W-1:0]           wb_cnt_o,
  output logic                       wb_mask_set_o,
  output logic [2*NUM_CH-1:0]        status_o
);

  // ---------------------------------------------------------------
  // per-channel views of the flattened register inputs
  // ---------------------------------------------------------------
  chan_mode_t        mode_a      [NUM_CH];
  logic [ADDR_W-1:0] cur_addr_a  [NUM_CH];
  logic [ADDR_W-1:0] base_addr_a [NUM_CH];
  logic [CNT_W-1:0]  cur_cnt_a   [NUM_CH];
  logic [CNT_W-1:0]  base_cnt_a  [NUM_CH];
  logic [PAGE_W-1:0] page_a      [NUM_CH];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      assign mode_a[c]      = mode_i[c*MODE_W +: MODE_W];
      assign cur_addr_a[c]  = cur_addr_i[c*ADDR_W +: ADDR_W];
      assign base_addr_a[c] = base_addr_i[c*ADDR_W +: ADDR_W];
      assign cur_cnt_a[c]   = cur_cnt_i[c*CNT_W +: CNT_W];
      assign base_cnt_a[c]  = base_cnt_i[c*CNT_W +: CNT_W];
      assign page_a[c]      = page_i[c*PAGE_W +: PAGE_W];
    end
  endgenerate

  // ---------------------------------------------------------------
  // arbitration
  // ---------------------------------------------------------------
  logic            any_elig;
  logic [CH_W-1:0] win;

  dma_prio_arb #(.NUM_CH(NUM_CH)) u_arb (
    .req_i  (req_i),
    .mask_i (mask_i),
    .any_o  (any_elig),
    .win_o  (win)
  );

  // ---------------------------------------------------------------
  // engine state and working copy of the granted channel
  // ---------------------------------------------------------------
  eng_state_e        state_q;
  logic [CH_W-1:0]   sel_q;
  logic [ADDR_W-1:0] w_addr_q;
  logic [CNT_W-1:0]  w_cnt_q;

  chan_mode_t        sel_mode;
  logic [PAGE_W-1:0] sel_page;
  logic [ADDR_W-1:0] sel_base_addr;
  logic [CNT_W-1:0]  sel_base_cnt;
  logic [NUM_CH-1:0] sel_oh;

  assign sel_mode      = mode_a[sel_q];
  assign sel_page      = page_a[sel_q];
  assign sel_base_addr = base_addr_a[sel_q];
  assign sel_base_cnt  = base_cnt_a[sel_q];
  assign sel_oh        = NUM_CH'(1) << sel_q;

  logic [ADDR_W-1:0] addr_next;
  logic [CNT_W-1:0]  cnt_next;
  logic              cnt_last;
  logic [PHYS_W-1:0] phys;

  dma_addr_step #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .PAGE_W    (PAGE_W),
    .WORD_MODE (WORD_MODE)
  ) u_step (
    .addr_i      (w_addr_q),
    .cnt_i       (w_cnt_q),
    .page_i      (sel_page),
    .dec_i       (sel_mode.dec),
    .addr_next_o (addr_next),
    .cnt_next_o  (cnt_next),
    .last_o      (cnt_last),
    .phys_o      (phys)
  );

  logic live;
  logic cascade;
  logic tc_evt;

  assign live    = hold_ack_i && req_i[sel_q] && !mask_i[sel_q];
  assign cascade = (sel_mode.svc == SVC_CASCADE);
  assign tc_evt  = (state_q == ST_BURST) && live && !cascade && cnt_last;

  // ---------------------------------------------------------------
  // sequencer with registered outputs
  // ---------------------------------------------------------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      sel_q         <= '0;
      w_addr_q      <= '0;
      w_cnt_q       <= '0;
      hold_req_o    <= 1'b0;
      ack_o         <= '0;
      mem_addr_o    <= '0;
      mem_stb_o     <= 1'b0;
      mem_wr_o      <= 1'b0;
      mem_rd_o      <= 1'b0;
      tc_o          <= 1'b0;
      wb_valid_o    <= 1'b0;
      wb_ch_o       <= '0;
      wb_addr_o     <= '0;
      wb_cnt_o      <= '0;
      wb_mask_set_o <= 1'b0;
    end else begin
      mem_stb_o     <= 1'b0;
      mem_wr_o      <= 1'b0;
      mem_rd_o      <= 1'b0;
      tc_o          <= 1'b0;
      wb_valid_o    <= 1'b0;
      wb_mask_set_o <= 1'b0;

      case (state_q)
        ST_IDLE: begin
          ack_o <= '0;
          if (any_elig) begin
            hold_req_o <= 1'b1;
            state_q    <= ST_HOLD;
          end
        end

        ST_HOLD: begin
          ack_o <= '0;
          if (!any_elig) begin
            hold_req_o <= 1'b0;
            state_q    <= ST_IDLE;
          end else if (hold_ack_i) begin
            sel_q    <= win;
            w_addr_q <= cur_addr_a[win];
            w_cnt_q  <= cur_cnt_a[win];
            state_q  <= ST_BURST;
          end
        end

        ST_BURST: begin
          if (live) begin
            ack_o <= sel_oh;
            if (!cascade) begin
              mem_addr_o <= phys;
              case (sel_mode.kind)
                XT_TO_MEM: begin
                  mem_stb_o <= 1'b1;
                  mem_wr_o  <= 1'b1;
                end
                XT_FROM_MEM: begin
                  mem_stb_o <= 1'b1;
                  mem_rd_o  <= 1'b1;
                end
                default: ;
              endcase
              wb_valid_o <= 1'b1;
              wb_ch_o    <= sel_q;
              if (cnt_last) begin
                tc_o       <= 1'b1;
                hold_req_o <= 1'b0;
                state_q    <= ST_REST;
                if (sel_mode.reload) begin
                  w_addr_q  <= sel_base_addr;
                  w_cnt_q   <= sel_base_cnt;
                  wb_addr_o <= sel_base_addr;
                  wb_cnt_o  <= sel_base_cnt;
                end else begin
                  w_addr_q      <= addr_next;
                  w_cnt_q       <= cnt_next;
                  wb_addr_o     <= addr_next;
                  wb_cnt_o      <= cnt_next;
                  wb_mask_set_o <= 1'b1;
                end
              end else begin
                w_addr_q  <= addr_next;
                w_cnt_q   <= cnt_next;
                wb_addr_o <= addr_next;
                wb_cnt_o  <= cnt_next;
              end
            end
          end else begin
            ack_o <= '0;
            if (any_elig) begin
              state_q <= ST_HOLD;
            end else begin
              hold_req_o <= 1'b0;
              state_q    <= ST_IDLE;
            end
          end
        end

        default: begin
          ack_o   <= '0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  dma_status_track #(.NUM_CH(NUM_CH)) u_status (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .tc_set_i (tc_evt),
    .tc_ch_i  (sel_q),
    .tc_clr_i (tc_clr_i),
    .status_o (status_o)
  );

  // ---------------------------------------------------------------
  // assertions
  // ---------------------------------------------------------------
  // R1: never more than one channel acknowledged
  a_r1_ack_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_o));

  // R4: an acknowledge only follows a cycle with the bus granted
  a_r4_ack_after_grant: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |-> $past(hold_ack_i));

  // R5: terminal count is only signalled alongside an acknowledge
  a_r5_tc_with_ack: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> (|ack_o));

  // R7: bus and acknowledge released right after terminal count
  a_r7_release_after_tc: assert property (@(posedge clk) disable iff (rst)
    tc_o |=> (!hold_req_o && (ack_o == '0) && !tc_o));

  // R8: a strobe always carries exactly one direction
  a_r8_one_direction: assert property (@(posedge clk) disable iff (rst)
    mem_stb_o |-> (mem_rd_o ^ mem_wr_o));

  // R11: cascade pass-through never writes back
  a_r11_cascade_quiet: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_BURST) && cascade) |=> !wb_valid_o);

endmodule

// File: tb/dma_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_engine_tb_top;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req = '0;
  logic [3:0]  mask = '0;
  logic [23:0] mode = '0;
  logic [63:0] cur_addr = '0;
  logic [63:0] base_addr = '0;
  logic [63:0] cur_cnt = '0;
  logic [63:0] base_cnt = '0;
  logic [31:0] page = '0;
  logic        tc_clr = 1'b0;
  logic        hold_ack = 1'b0;

  logic        hold_req;
  logic [3:0]  ack;
  logic [23:0] mem_addr;
  logic        mem_stb, mem_wr, mem_rd, tc;
  logic        wb_valid;
  logic [1:0]  wb_ch;
  logic [15:0] wb_addr, wb_cnt;
  logic        wb_mask;
  logic [7:0]  status;

  logic        w_hold_req;
  logic [3:0]  w_ack;
  logic [23:0] w_mem_addr;
  logic        w_stb, w_wr, w_rd, w_tc, w_wb_valid, w_wb_mask;
  logic [1:0]  w_wb_ch;
  logic [15:0] w_wb_addr, w_wb_cnt;
  logic [7:0]  w_status;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_xfer_engine #(.WORD_MODE(0)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .mask_i(mask), .mode_i(mode),
    .cur_addr_i(cur_addr), .base_addr_i(base_addr), .cur_cnt_i(cur_cnt),
    .base_cnt_i(base_cnt), .page_i(page), .tc_clr_i(tc_clr),
    .hold_ack_i(hold_ack), .hold_req_o(hold_req), .ack_o(ack),
    .mem_addr_o(mem_addr), .mem_stb_o(mem_stb), .mem_wr_o(mem_wr),
    .mem_rd_o(mem_rd), .tc_o(tc), .wb_valid_o(wb_valid), .wb_ch_o(wb_ch),
    .wb_addr_o(wb_addr), .wb_cnt_o(wb_cnt), .wb_mask_set_o(wb_mask),
    .status_o(status));

  dma_xfer_engine #(.WORD_MODE(1)) dut_w (
    .clk(clk), .rst(rst), .req_i(req), .mask_i(mask), .mode_i(mode),
    .cur_addr_i(cur_addr), .base_addr_i(base_addr), .cur_cnt_i(cur_cnt),
    .base_cnt_i(base_cnt), .page_i(page), .tc_clr_i(tc_clr),
    .hold_ack_i(hold_ack), .hold_req_o(w_hold_req), .ack_o(w_ack),
    .mem_addr_o(w_mem_addr), .mem_stb_o(w_stb), .mem_wr_o(w_wr),
    .mem_rd_o(w_rd), .tc_o(w_tc), .wb_valid_o(w_wb_valid), .wb_ch_o(w_wb_ch),
    .wb_addr_o(w_wb_addr), .wb_cnt_o(w_wb_cnt), .wb_mask_set_o(w_wb_mask),
    .status_o(w_status));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_chan(input int ch, input logic [5:0] md, input logic [15:0] ca,
                          input logic [15:0] cc, input logic [15:0] ba,
                          input logic [15:0] bc, input logic [7:0] pg);
    mode[ch*6 +: 6]       = md;
    cur_addr[ch*16 +: 16] = ca;
    cur_cnt[ch*16 +: 16]  = cc;
    base_addr[ch*16 +: 16] = ba;
    base_cnt[ch*16 +: 16] = bc;
    page[ch*8 +: 8]       = pg;
  endtask

  // runs one burst on channel ch up to terminal count and checks it
  task automatic burst(input int ch, input int n_exp, input logic [23:0] first_a,
                       input logic [23:0] last_a, input logic exp_stb,
                       input logic exp_wr, input logic exp_rd,
                       input logic [15:0] exp_wba, input logic [15:0] exp_wbc,
                       input logic exp_msk, output logic [23:0] first_w);
    int seen = 0;
    int first_k = 0;
    logic [23:0] last_seen = '0;
    logic saw_tc = 1'b0;
    first_w = '0;
    req[ch] = 1'b1;
    tick();
    chk("R2 hold request raised", 32'(hold_req), 32'd1);
    hold_ack = 1'b1;
    tick();
    for (int k = 1; k <= 80; k++) begin
      tick();
      if (ack[ch]) begin
        seen++;
        if (seen == 1) begin
          first_k = k;
          chk("R3 first address", 32'(mem_addr), 32'(first_a));
          first_w = w_mem_addr;
        end
        last_seen = mem_addr;
      end
      if (tc) begin
        saw_tc = 1'b1;
        chk("R5 tc with ack", 32'(ack), 32'(4'(1) << ch));
        chk("R8 strobe", 32'(mem_stb), 32'(exp_stb));
        chk("R8 write flag", 32'(mem_wr), 32'(exp_wr));
        chk("R8 read flag", 32'(mem_rd), 32'(exp_rd));
        chk("R6 wb valid", 32'({wb_valid, 2'(wb_ch)}), 32'({1'b1, 2'(ch)}));
        chk("R6 wb address", 32'(wb_addr), 32'(exp_wba));
        chk("R6 wb count", 32'(wb_cnt), 32'(exp_wbc));
        chk("R6 wb mask set", 32'(wb_mask), 32'(exp_msk));
        chk("R5 tc status bit", 32'(status[ch]), 32'd1);
        break;
      end
    end
    req[ch] = 1'b0;
    hold_ack = 1'b0;
    chk("R5 terminal count seen", 32'(saw_tc), 32'd1);
    chk("R5 transfer count N+1", 32'(seen), 32'(n_exp));
    chk("R4 first transfer latency", 32'(first_k), 32'd1);
    chk("R4 last address", 32'(last_seen), 32'(last_a));
    tick();
    chk("R7 release after tc", 32'({hold_req, ack, tc}), 32'd0);
    tick();
  endtask

  task automatic test_reset();
    chk("R12 reset outputs", 32'({hold_req, ack, mem_stb, tc, wb_valid}), 32'd0);
    chk("R12 reset status", 32'(status), 32'd0);
  endtask

  task automatic test_inc_read();
    logic [23:0] fw;
    set_chan(2, 6'h02, 16'h8000, 16'd3, 16'h0000, 16'h0000, 8'h12);
    burst(2, 4, 24'h128000, 24'h128003, 1'b1, 1'b0, 1'b1, 16'h8004, 16'hFFFF, 1'b1, fw);
    chk("R3 word mode address", 32'(fw), 32'h130000);
  endtask

  task automatic test_dec_write();
    logic [23:0] fw;
    set_chan(1, 6'h09, 16'h0010, 16'd0, 16'h0000, 16'h0000, 8'h03);
    burst(1, 1, 24'h030010, 24'h030010, 1'b1, 1'b1, 1'b0, 16'h000F, 16'hFFFF, 1'b1, fw);
  endtask

  task automatic test_autoinit();
    logic [23:0] fw;
    set_chan(3, 6'h06, 16'h0100, 16'd1, 16'h0200, 16'h0005, 8'h00);
    burst(3, 2, 24'h000100, 24'h000101, 1'b1, 1'b0, 1'b1, 16'h0200, 16'h0005, 1'b0, fw);
  endtask

  task automatic test_verify();
    logic [23:0] fw;
    set_chan(0, 6'h00, 16'h0040, 16'd2, 16'h0000, 16'h0000, 8'h01);
    burst(0, 3, 24'h010040, 24'h010042, 1'b0, 1'b0, 1'b0, 16'h0043, 16'hFFFF, 1'b1, fw);
  endtask

  task automatic test_tc_clear();
    chk("R10 tc bits sticky", 32'(status[3:0]), 32'hF);
    tc_clr = 1'b1;
    tick();
    tc_clr = 1'b0;
    chk("R10 tc bits cleared", 32'(status[3:0]), 32'h0);
    tick();
    chk("R10 stays clear", 32'(status[3:0]), 32'h0);
  endtask

  task automatic test_priority_drop();
    set_chan(1, 6'h02, 16'h0000, 16'h0010, 16'h0, 16'h0, 8'h00);
    set_chan(3, 6'h02, 16'h0000, 16'h0010, 16'h0, 16'h0, 8'h00);
    req = 4'b1010;
    tick();
    hold_ack = 1'b1;
    tick();
    tick();
    chk("R1 lower index wins", 32'(ack), 32'b0010);
    req = 4'b1000;
    tick();
    chk("R9 ack drops on request removal", 32'({ack, tc}), 32'd0);
    chk("R9 hold kept for other channel", 32'(hold_req), 32'd1);
    chk("R9 pending status follows request", 32'(status[7:4]), 32'b1000);
    tick();
    tick();
    chk("R9 next channel served", 32'(ack), 32'b1000);
    req = 4'b0000;
    hold_ack = 1'b0;
    tick();
    chk("R2 hold drops with no request", 32'({hold_req, ack}), 32'd0);
    tick();
  endtask

  task automatic test_masked();
    mask = 4'b0001;
    req = 4'b0101;
    tick();
    hold_ack = 1'b1;
    tick();
    tick();
    chk("R1 masked channel skipped", 32'(ack), 32'b0100);
    req = 4'b0000;
    hold_ack = 1'b0;
    tick();
    tick();
    mask = 4'b0100;
    req = 4'b0100;
    hold_ack = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R2 masked request ignored", 32'({hold_req, ack, mem_stb, tc}), 32'd0);
    end
    req = 4'b0000;
    hold_ack = 1'b0;
    mask = 4'b0000;
    tick();
  endtask

  task automatic test_cascade();
    set_chan(0, 6'h30, 16'h0000, 16'h0000, 16'h0, 16'h0, 8'h00);
    req = 4'b0001;
    tick();
    hold_ack = 1'b1;
    tick();
    tick();
    chk("R11 cascade ack passed", 32'(ack), 32'b0001);
    chk("R11 cascade no strobe or wb", 32'({mem_stb, wb_valid, tc}), 32'd0);
    tick();
    tick();
    chk("R11 cascade holds without tc", 32'({ack, tc}), 32'b00010);
    req = 4'b0000;
    hold_ack = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    tick();
    tick();
    rst = 1'b0;
    tick();
    test_reset();
    test_inc_read();
    test_dec_write();
    test_autoinit();
    test_verify();
    test_tc_clear();
    test_priority_drop();
    test_masked();
    test_cascade();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule